// File: doc/BRIEF.md
# Banked UART Register Access Decoder

This block is the register-file front end of one serial channel. A host drives a 3-bit address, a chip select, read and write strobes and an 8-bit write bus. The block decides which internal register a read returns and which register a write updates. That decision depends on the line-control register it holds and on one bit of its feature-control register.

Line control picks one of three overlapping banks. When bit 7 is clear, the normal bank is active. When bit 7 is set and the byte is any value other than 0xBF, the divisor bank is active. When the byte is exactly 0xBF, the enhanced bank is active. The block stores line control, the two divisor bytes, the alternate-function, interrupt-enable, modem-control, scratch, feature-control and enhanced-function registers, and four flow-control characters.

Receive data, interrupt status, line status, modem status and the two FIFO level values come in from the surrounding logic as read-only inputs. Writes to holding registers and other write-only registers leave the block as one-cycle write pulses, and the surrounding logic takes the data from the write bus. Reads of a holding register or a status register raise a read strobe, so that FIFO and status logic can pop an entry or clear flags.

Top module: `uart_bank_decoder`

## Requirements
- R1: After reset, line control reads 0x03. Every other stored register reads 0x00: divisor, alternate function, interrupt enable, modem control, scratch, feature control, enhanced function and the flow characters.
- R2: In the normal bank (line control bit 7 = 0), a read of address 0 returns `rx_data_i` and pulses `rx_pop_o`. A write to address 0 pulses `thr_we_o`.
- R3: In the normal bank, address 1 is the interrupt-enable register, readable and writable. A read of address 2 returns `int_stat_i` and pulses `isr_rd_o`. A write to address 2 pulses `fcr_we_o`.
- R4: Address 3 reads and writes line control in every bank. The bank is chosen from the line-control value held in the cycle of the access, so a new line-control value applies from the next access on.
- R5: In the divisor bank (bit 7 = 1 and line control ≠ 0xBF), addresses 0, 1 and 2 read and write the divisor low byte, the divisor high byte and the alternate-function register. `divisor_o` carries them as {high, low}.
- R6: In the divisor bank, while both divisor bytes are 0x00, a read of address 0 returns REV_CODE and a read of address 1 returns DEVID_CODE. Writes to those addresses still load the divisor bytes.
- R7: In the normal and divisor banks, address 4 is modem control, readable and writable. A read of address 5 returns `line_stat_i` and pulses `lsr_rd_o`. A read of address 6 returns `modem_stat_i` and pulses `msr_rd_o`. Writes to addresses 5 and 6 change no stored register.
- R8: At address 7 in the normal bank, feature-control bit 6 selects the target. With bit 6 = 0, address 7 is the scratch register. With bit 6 = 1, a read returns `fifo_fill_i`, and a write pulses `emsr_we_o` and leaves scratch unchanged. In the divisor bank, address 7 is always scratch.
- R9: In the enhanced bank (line control = 0xBF), address 0 reads `fifo_cnt_i` and a write to it pulses `trg_we_o`. Address 1 is feature control and address 2 is enhanced function. Addresses 4 to 7 are flow characters 0 to 3, and character k sits at `xchar_o[8k+7:8k]`.
- R10: When `cs_i` is low, writes are ignored and no pulse or strobe is raised. `rdata_o` is 0x00 unless both `cs_i` and `rd_i` are high.
- R11: Read strobes are combinational with the read cycle, and at most one is high in a cycle. In the enhanced bank, reads of addresses 0, 5 and 6 raise none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Chip select |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| rx_data_i | input | 8 | Receive holding data |
| int_stat_i | input | 8 | Interrupt status |
| line_stat_i | input | 8 | Line status |
| modem_stat_i | input | 8 | Modem status |
| fifo_fill_i | input | 8 | FIFO level shown at address 7 |
| fifo_cnt_i | input | 8 | FIFO level count shown in the enhanced bank |
| rx_pop_o | output | 1 | Receive holding read strobe |
| isr_rd_o | output | 1 | Interrupt status read strobe |
| lsr_rd_o | output | 1 | Line status read strobe |
| msr_rd_o | output | 1 | Modem status read strobe |
| thr_we_o | output | 1 | Transmit holding write pulse |
| fcr_we_o | output | 1 | FIFO control write pulse |
| emsr_we_o | output | 1 | Enhanced mode select write pulse |
| trg_we_o | output | 1 | Trigger level write pulse |
| lcr_o | output | 8 | Line control |
| divisor_o | output | 16 | Divisor {high, low} |
| afr_o | output | 8 | Alternate function |
| ier_o | output | 8 | Interrupt enable |
| mcr_o | output | 8 | Modem control |
| fctr_o | output | 8 | Feature control |
| efr_o | output | 8 | Enhanced function |
| xchar_o | output | 32 | Flow characters 3..0 |

## Verification
A wrong line-control value sends every later access to the wrong bank. It shows on the first read after the offending write, for example as a revision code where receive data was expected. A wrong divisor byte can make identification codes appear or vanish on the next read of address 0 or 1. A mis-decoded address shows in the same cycle as a missing or misplaced strobe or pulse. A write landing in the wrong register shows one clock later on the configuration outputs.

// File: rtl/sbk_pkg.sv
package sbk_pkg;
  localparam int NXC = 4;
  localparam logic [7:0] ENH_KEY = 8'hBF;
  localparam int REMAP_BIT = 6;

  typedef enum logic [1:0] {BANK_NORM, BANK_DIV, BANK_ENH} bank_e;

  typedef enum logic [4:0] {
    SRC_NONE, SRC_RHR, SRC_DLL, SRC_DLM, SRC_REV, SRC_DID, SRC_AFR,
    SRC_IER, SRC_ISR, SRC_LCR, SRC_MCR, SRC_LSR, SRC_MSR, SRC_SPR,
    SRC_FLVL, SRC_FCNT, SRC_FCTR, SRC_EFR, SRC_XC0, SRC_XC1, SRC_XC2,
    SRC_XC3
  } rsrc_e;

  typedef enum logic [4:0] {
    DST_NONE, DST_THR, DST_DLL, DST_DLM, DST_AFR, DST_IER, DST_FCR,
    DST_LCR, DST_MCR, DST_SPR, DST_EMSR, DST_TRG, DST_FCTR, DST_EFR,
    DST_XC0, DST_XC1, DST_XC2, DST_XC3
  } wdst_e;

  // storage slots of the register file
  localparam int SLOT_LCR  = 0;
  localparam int SLOT_DLL  = 1;
  localparam int SLOT_DLM  = 2;
  localparam int SLOT_AFR  = 3;
  localparam int SLOT_IER  = 4;
  localparam int SLOT_MCR  = 5;
  localparam int SLOT_SPR  = 6;
  localparam int SLOT_FCTR = 7;
  localparam int SLOT_EFR  = 8;
  localparam int SLOT_XC0  = 9;
  localparam int NSLOT     = SLOT_XC0 + NXC;

  function automatic int slot_of(input wdst_e d);
    case (d)
      DST_LCR:  return SLOT_LCR;
      DST_DLL:  return SLOT_DLL;
      DST_DLM:  return SLOT_DLM;
      DST_AFR:  return SLOT_AFR;
      DST_IER:  return SLOT_IER;
      DST_MCR:  return SLOT_MCR;
      DST_SPR:  return SLOT_SPR;
      DST_FCTR: return SLOT_FCTR;
      DST_EFR:  return SLOT_EFR;
      DST_XC0:  return SLOT_XC0;
      DST_XC1:  return SLOT_XC0 + 1;
      DST_XC2:  return SLOT_XC0 + 2;
      DST_XC3:  return SLOT_XC0 + 3;
      default:  return -1;
    endcase
  endfunction
endpackage

// File: rtl/sbk_rst_sync.sv
module sbk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/sbk_bank_sel.sv
module sbk_bank_sel
  import sbk_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] lcr_i,
  output bank_e         bank_o
);
  always_comb begin
    if (lcr_i == DW'(ENH_KEY)) bank_o = BANK_ENH;
    else if (lcr_i[DW-1])      bank_o = BANK_DIV;
    else                       bank_o = BANK_NORM;
  end
endmodule

// File: rtl/sbk_addr_map.sv
module sbk_addr_map
  import sbk_pkg::*;
(
  input  bank_e      bank_i,
  input  logic [2:0] addr_i,
  input  logic       remap_i,
  input  logic       div_zero_i,
  output rsrc_e      rsrc_o,
  output wdst_e      wdst_o
);
  always_comb begin
    rsrc_o = SRC_NONE;
    wdst_o = DST_NONE;
    unique case (bank_i)
      BANK_ENH: begin
        case (addr_i)
          3'd0: begin rsrc_o = SRC_FCNT; wdst_o = DST_TRG;  end
          3'd1: begin rsrc_o = SRC_FCTR; wdst_o = DST_FCTR; end
          3'd2: begin rsrc_o = SRC_EFR;  wdst_o = DST_EFR;  end
          3'd3: begin rsrc_o = SRC_LCR;  wdst_o = DST_LCR;  end
          3'd4: begin rsrc_o = SRC_XC0;  wdst_o = DST_XC0;  end
          3'd5: begin rsrc_o = SRC_XC1;  wdst_o = DST_XC1;  end
          3'd6: begin rsrc_o = SRC_XC2;  wdst_o = DST_XC2;  end
          default: begin rsrc_o = SRC_XC3; wdst_o = DST_XC3; end
        endcase
      end
      BANK_DIV: begin
        case (addr_i)
          3'd0: begin rsrc_o = div_zero_i ? SRC_REV : SRC_DLL; wdst_o = DST_DLL; end
          3'd1: begin rsrc_o = div_zero_i ? SRC_DID : SRC_DLM; wdst_o = DST_DLM; end
          3'd2: begin rsrc_o = SRC_AFR; wdst_o = DST_AFR; end
          3'd3: begin rsrc_o = SRC_LCR; wdst_o = DST_LCR; end
          3'd4: begin rsrc_o = SRC_MCR; wdst_o = DST_MCR; end
          3'd5: rsrc_o = SRC_LSR;
          3'd6: rsrc_o = SRC_MSR;
          default: begin rsrc_o = SRC_SPR; wdst_o = DST_SPR; end
        endcase
      end
      default: begin
        case (addr_i)
          3'd0: begin rsrc_o = SRC_RHR; wdst_o = DST_THR; end
          3'd1: begin rsrc_o = SRC_IER; wdst_o = DST_IER; end
          3'd2: begin rsrc_o = SRC_ISR; wdst_o = DST_FCR; end
          3'd3: begin rsrc_o = SRC_LCR; wdst_o = DST_LCR; end
          3'd4: begin rsrc_o = SRC_MCR; wdst_o = DST_MCR; end
          3'd5: rsrc_o = SRC_LSR;
          3'd6: rsrc_o = SRC_MSR;
          default: begin
            if (remap_i) begin rsrc_o = SRC_FLVL; wdst_o = DST_EMSR; end
            else         begin rsrc_o = SRC_SPR;  wdst_o = DST_SPR;  end
          end
        endcase
      end
    endcase
  end
endmodule

// File: rtl/sbk_regfile.sv
module sbk_regfile
  import sbk_pkg::*;
#(
  parameter int            DW      = 8,
  parameter logic [DW-1:0] LCR_RST = 8'h03
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  wdst_e             wdst_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [NSLOT*DW-1:0] regs_o
);
  logic [NSLOT-1:0] en;
  logic [DW-1:0]    nxt [NSLOT];
  logic [DW-1:0]    q   [NSLOT];

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    localparam logic [DW-1:0] RST_VAL = (g == SLOT_LCR) ? LCR_RST : '0;

    always_comb begin
      en[g]  = we_i && (slot_of(wdst_i) == g);
      nxt[g] = wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    q[g] <= RST_VAL;
      else if (en[g]) q[g] <= nxt[g];
    end

    assign regs_o[g*DW +: DW] = q[g];
  end

  // a line-control write lands in the following cycle
  p_lcr_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wdst_i == DST_LCR) |=> (q[SLOT_LCR] == $past(wdata_i)));

  // read-only or pulse targets leave all storage untouched
  p_no_store_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && slot_of(wdst_i) < 0) |=> $stable(regs_o));
endmodule

// File: rtl/uart_bank_decoder.sv
module uart_bank_decoder
  import sbk_pkg::*;
#(
  parameter int            DW         = 8,
  parameter logic [DW-1:0] LCR_RST    = 8'h03,
  parameter logic [DW-1:0] REV_CODE   = 8'h21,
  parameter logic [DW-1:0] DEVID_CODE = 8'h0A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [2:0]        addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [DW-1:0]     rx_data_i,
  input  logic [DW-1:0]     int_stat_i,
  input  logic [DW-1:0]     line_stat_i,
  input  logic [DW-1:0]     modem_stat_i,
  input  logic [DW-1:0]     fifo_fill_i,
  input  logic [DW-1:0]     fifo_cnt_i,
  output logic              rx_pop_o,
  output logic              isr_rd_o,
  output logic              lsr_rd_o,
  output logic              msr_rd_o,
  output logic              thr_we_o,
  output logic              fcr_we_o,
  output logic              emsr_we_o,
  output logic              trg_we_o,
  output logic [DW-1:0]     lcr_o,
  output logic [2*DW-1:0]   divisor_o,
  output logic [DW-1:0]     afr_o,
  output logic [DW-1:0]     ier_o,
  output logic [DW-1:0]     mcr_o,
  output logic [DW-1:0]     fctr_o,
  output logic [DW-1:0]     efr_o,
  output logic [NXC*DW-1:0] xchar_o
);
  logic              rst_n;
  logic [NSLOT*DW-1:0] regs;
  bank_e             bank;
  rsrc_e             rsrc;
  wdst_e             wdst;
  logic              rd_act, wr_act, div_zero;
  logic [DW-1:0]     spr;

  sbk_rst_sync #(.STAGES(2)) u_rst (
    .clk_i (clk_i), .rst_ni (rst_ni), .rst_no (rst_n)
  );

  assign lcr_o     = regs[SLOT_LCR*DW  +: DW];
  assign divisor_o = {regs[SLOT_DLM*DW +: DW], regs[SLOT_DLL*DW +: DW]};
  assign afr_o     = regs[SLOT_AFR*DW  +: DW];
  assign ier_o     = regs[SLOT_IER*DW  +: DW];
  assign mcr_o     = regs[SLOT_MCR*DW  +: DW];
  assign spr       = regs[SLOT_SPR*DW  +: DW];
  assign fctr_o    = regs[SLOT_FCTR*DW +: DW];
  assign efr_o     = regs[SLOT_EFR*DW  +: DW];
  assign xchar_o   = regs[SLOT_XC0*DW  +: NXC*DW];

  assign div_zero = (divisor_o == '0);
  assign rd_act   = cs_i && rd_i;
  assign wr_act   = cs_i && wr_i;

  sbk_bank_sel #(.DW(DW)) u_bank (
    .lcr_i (lcr_o), .bank_o (bank)
  );

  sbk_addr_map u_map (
    .bank_i     (bank),
    .addr_i     (addr_i),
    .remap_i    (fctr_o[REMAP_BIT]),
    .div_zero_i (div_zero),
    .rsrc_o     (rsrc),
    .wdst_o     (wdst)
  );

  sbk_regfile #(.DW(DW), .LCR_RST(LCR_RST)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .we_i    (wr_act),
    .wdst_i  (wdst),
    .wdata_i (wdata_i),
    .regs_o  (regs)
  );

  // read data multiplexer
  always_comb begin
    rdata_o = '0;
    if (rd_act) begin
      case (rsrc)
        SRC_RHR:  rdata_o = rx_data_i;
        SRC_DLL:  rdata_o = divisor_o[DW-1:0];
        SRC_DLM:  rdata_o = divisor_o[2*DW-1:DW];
        SRC_REV:  rdata_o = REV_CODE;
        SRC_DID:  rdata_o = DEVID_CODE;
        SRC_AFR:  rdata_o = afr_o;
        SRC_IER:  rdata_o = ier_o;
        SRC_ISR:  rdata_o = int_stat_i;
        SRC_LCR:  rdata_o = lcr_o;
        SRC_MCR:  rdata_o = mcr_o;
        SRC_LSR:  rdata_o = line_stat_i;
        SRC_MSR:  rdata_o = modem_stat_i;
        SRC_SPR:  rdata_o = spr;
        SRC_FLVL: rdata_o = fifo_fill_i;
        SRC_FCNT: rdata_o = fifo_cnt_i;
        SRC_FCTR: rdata_o = fctr_o;
        SRC_EFR:  rdata_o = efr_o;
        SRC_XC0:  rdata_o = xchar_o[0*DW +: DW];
        SRC_XC1:  rdata_o = xchar_o[1*DW +: DW];
        SRC_XC2:  rdata_o = xchar_o[2*DW +: DW];
        SRC_XC3:  rdata_o = xchar_o[3*DW +: DW];
        default:  rdata_o = '0;
      endcase
    end
  end

  // strobes and write pulses
  always_comb begin
    rx_pop_o  = rd_act && (rsrc == SRC_RHR);
    isr_rd_o  = rd_act && (rsrc == SRC_ISR);
    lsr_rd_o  = rd_act && (rsrc == SRC_LSR);
    msr_rd_o  = rd_act && (rsrc == SRC_MSR);
    thr_we_o  = wr_act && (wdst == DST_THR);
    fcr_we_o  = wr_act && (wdst == DST_FCR);
    emsr_we_o = wr_act && (wdst == DST_EMSR);
    trg_we_o  = wr_act && (wdst == DST_TRG);
  end

  p_cs_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_n)
    !cs_i |-> (rdata_o == '0) && !thr_we_o && !fcr_we_o && !emsr_we_o &&
              !trg_we_o && !rx_pop_o && !isr_rd_o && !lsr_rd_o && !msr_rd_o);

  p_cs_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_n)
    !cs_i |=> $stable(lcr_o) && $stable(divisor_o) && $stable(xchar_o) &&
              $stable(ier_o) && $stable(mcr_o) && $stable(fctr_o));

  p_one_strobe_r11: assert property (@(posedge clk_i) disable iff (!rst_n)
    $onehot0({rx_pop_o, isr_rd_o, lsr_rd_o, msr_rd_o}));

  p_thr_bank_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    thr_we_o |-> !lcr_o[DW-1] && wr_i && cs_i);

  p_trg_bank_r9: assert property (@(posedge clk_i) disable iff (!rst_n)
    trg_we_o |-> (lcr_o == DW'(ENH_KEY)));

  p_div_load_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_act && addr_i == 3'd0 && lcr_o[DW-1] && lcr_o != DW'(ENH_KEY))
      |=> (divisor_o[DW-1:0] == $past(wdata_i)));
endmodule

// File: tb/uart_bank_decoder_tb_top.sv
module uart_bank_decoder_tb_top;
  localparam logic [7:0] REV = 8'h21;
  localparam logic [7:0] DID = 8'h0A;
  localparam logic [7:0] RXD = 8'h5A, ISR = 8'hC1, LSR = 8'h60;
  localparam logic [7:0] MSR = 8'hB0, FLV = 8'h11, FCN = 8'h22;

  typedef struct packed {
    logic       wr;
    logic       rd;
    logic [2:0] a;
    logic [7:0] d;
    logic [7:0] e;
    logic [3:0] r;
  } vec_t;

  localparam int NV = 44;
  localparam vec_t VEC [NV] = '{
    {1'b0,1'b1,3'd3,8'h00,8'h03,4'd1},  // R1 line control reset
    {1'b0,1'b1,3'd1,8'h00,8'h00,4'd1},  // R1 ier reset
    {1'b0,1'b1,3'd7,8'h00,8'h00,4'd1},  // R1 scratch reset
    {1'b0,1'b1,3'd0,8'h00,RXD  ,4'd2},  // R2 receive data
    {1'b1,1'b0,3'd1,8'h55,8'h00,4'd3},
    {1'b0,1'b1,3'd1,8'h00,8'h55,4'd3},  // R3 ier
    {1'b0,1'b1,3'd2,8'h00,ISR  ,4'd3},  // R3 status
    {1'b0,1'b1,3'd5,8'h00,LSR  ,4'd7},  // R7 line status
    {1'b0,1'b1,3'd6,8'h00,MSR  ,4'd7},  // R7 modem status
    {1'b1,1'b0,3'd4,8'h1F,8'h00,4'd7},
    {1'b0,1'b1,3'd4,8'h00,8'h1F,4'd7},  // R7 mcr
    {1'b1,1'b0,3'd5,8'hFF,8'h00,4'd7},
    {1'b1,1'b0,3'd6,8'hFF,8'h00,4'd7},
    {1'b0,1'b1,3'd4,8'h00,8'h1F,4'd7},  // R7 mcr untouched
    {1'b1,1'b0,3'd7,8'h77,8'h00,4'd8},
    {1'b0,1'b1,3'd7,8'h00,8'h77,4'd8},  // R8 scratch
    {1'b1,1'b0,3'd3,8'h80,8'h00,4'd4},
    {1'b0,1'b1,3'd0,8'h00,REV  ,4'd6},  // R6 revision
    {1'b0,1'b1,3'd1,8'h00,DID  ,4'd6},  // R6 identification
    {1'b1,1'b0,3'd0,8'h0C,8'h00,4'd5},
    {1'b0,1'b1,3'd0,8'h00,8'h0C,4'd5},  // R5 divisor low
    {1'b0,1'b1,3'd1,8'h00,8'h00,4'd5},  // R5 divisor high
    {1'b1,1'b0,3'd2,8'h3C,8'h00,4'd5},
    {1'b0,1'b1,3'd2,8'h00,8'h3C,4'd5},  // R5 afr
    {1'b0,1'b1,3'd7,8'h00,8'h77,4'd8},  // R8 scratch in divisor bank
    {1'b1,1'b0,3'd0,8'h00,8'h00,4'd6},
    {1'b0,1'b1,3'd0,8'h00,REV  ,4'd6},  // R6 revision again
    {1'b1,1'b0,3'd1,8'h02,8'h00,4'd6},
    {1'b0,1'b1,3'd1,8'h00,8'h02,4'd6},  // R6 write loaded high byte
    {1'b1,1'b0,3'd3,8'hBF,8'h00,4'd4},
    {1'b0,1'b1,3'd3,8'h00,8'hBF,4'd4},  // R4
    {1'b0,1'b1,3'd0,8'h00,FCN  ,4'd9},  // R9 fifo count
    {1'b1,1'b0,3'd1,8'h40,8'h00,4'd9},
    {1'b0,1'b1,3'd1,8'h00,8'h40,4'd9},  // R9 fctr
    {1'b1,1'b0,3'd2,8'h10,8'h00,4'd9},
    {1'b0,1'b1,3'd2,8'h00,8'h10,4'd9},  // R9 efr
    {1'b1,1'b0,3'd4,8'h11,8'h00,4'd9},
    {1'b1,1'b0,3'd5,8'hE1,8'h00,4'd9},
    {1'b1,1'b0,3'd6,8'h13,8'h00,4'd9},
    {1'b1,1'b0,3'd7,8'h93,8'h00,4'd9},
    {1'b0,1'b1,3'd5,8'h00,8'hE1,4'd9},  // R9 char 1
    {1'b1,1'b0,3'd3,8'h03,8'h00,4'd4},
    {1'b0,1'b1,3'd7,8'h00,FLV  ,4'd8},  // R8 remapped read
    {1'b0,1'b1,3'd1,8'h00,8'h55,4'd3}   // R3 ier kept
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic rx_pop, isr_rd, lsr_rd, msr_rd, thr_we, fcr_we, emsr_we, trg_we;
  logic [7:0] lcr, afr, ier, mcr, fctr, efr;
  logic [15:0] divisor;
  logic [31:0] xchar;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  uart_bank_decoder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .rd_i(rd), .wr_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .rx_data_i(RXD), .int_stat_i(ISR), .line_stat_i(LSR),
    .modem_stat_i(MSR), .fifo_fill_i(FLV), .fifo_cnt_i(FCN),
    .rx_pop_o(rx_pop), .isr_rd_o(isr_rd), .lsr_rd_o(lsr_rd),
    .msr_rd_o(msr_rd), .thr_we_o(thr_we), .fcr_we_o(fcr_we),
    .emsr_we_o(emsr_we), .trg_we_o(trg_we), .lcr_o(lcr),
    .divisor_o(divisor), .afr_o(afr), .ier_o(ier), .mcr_o(mcr),
    .fctr_o(fctr), .efr_o(efr), .xchar_o(xchar)
  );

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one access at the falling edge; outputs settle 1 ns later
  task automatic drive(input logic c, input logic w, input logic r,
                       input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cs = c; wr = w; rd = r; addr = a; wdata = d;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    cs = 0; wr = 0; rd = 0;
  endtask

  function automatic logic [3:0] strobes();
    return {rx_pop, isr_rd, lsr_rd, msr_rd};
  endfunction

  initial begin : watchdog
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state on the configuration outputs
    check("R1", {lcr, afr, ier, mcr}, {8'h03, 24'h0});
    check("R1", {divisor, fctr, efr}, 32'h0);
    check("R1", xchar, 32'h0);

    for (int i = 0; i < NV; i++) begin
      drive(1'b1, VEC[i].wr, VEC[i].rd, VEC[i].a, VEC[i].d);
      if (VEC[i].rd) begin
        checks++;
        if (rdata !== VEC[i].e) begin
          errors++;
          $display("FAIL R%0d vector %0d: actual %h expected %h",
                   VEC[i].r, i, rdata, VEC[i].e);
        end
      end
    end
    idle();
    check("R9", xchar, 32'h9313E111);
    check("R5", divisor, 16'h0200);
    check("R9", {fctr, efr}, 16'h4010);

    // R8 remapped write pulses emsr and spares scratch
    drive(1, 1, 0, 3'd7, 8'hEE);
    check("R8", {emsr_we, thr_we, fcr_we, trg_we}, 4'b1000);
    idle();
    drive(1, 1, 0, 3'd3, 8'hBF); drive(1, 1, 0, 3'd1, 8'h00);
    drive(1, 1, 0, 3'd3, 8'h03);
    drive(1, 0, 1, 3'd7, 8'h00);
    check("R8", rdata, 8'h77);
    // R2 read strobe and write pulse
    drive(1, 0, 1, 3'd0, 8'h00);
    check("R2", strobes(), 4'b1000);
    drive(1, 1, 0, 3'd0, 8'hAB);
    check("R2", {thr_we, fcr_we, emsr_we, trg_we}, 4'b1000);
    // R3 status strobe and fifo-control pulse
    drive(1, 0, 1, 3'd2, 8'h00);
    check("R3", strobes(), 4'b0100);
    drive(1, 1, 0, 3'd2, 8'h07);
    check("R3", {thr_we, fcr_we, emsr_we, trg_we}, 4'b0100);
    // R7 status strobes
    drive(1, 0, 1, 3'd5, 8'h00);
    check("R7", strobes(), 4'b0010);
    drive(1, 0, 1, 3'd6, 8'h00);
    check("R7", strobes(), 4'b0001);
    // R10 chip select low: no effect, zero read data
    drive(0, 1, 1, 3'd3, 8'h80);
    check("R10", {rdata, strobes(), thr_we, fcr_we, emsr_we, trg_we}, 16'h0);
    idle();
    check("R10", lcr, 8'h03);
    drive(1, 0, 0, 3'd3, 8'h00);
    check("R10", rdata, 8'h00);
    // R4 new line control applies to the next access only
    drive(1, 1, 1, 3'd3, 8'hBF);
    check("R4", rdata, 8'h03);
    drive(1, 0, 1, 3'd5, 8'h00);
    check("R11", {rdata, strobes()}, {8'hE1, 4'b0000});
    drive(1, 0, 1, 3'd0, 8'h00);
    check("R11", strobes(), 4'b0000);
    drive(1, 1, 0, 3'd0, 8'h05);
    check("R9", {thr_we, fcr_we, emsr_we, trg_we}, 4'b0001);
    idle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule